// File: doc/BRIEF.md
# Palette Bypass Output Formatter

This block is the last stage of a pixel pipeline, just before the video output. Each cycle it receives three things for the current pixel:

- the 8-bit pixel index, a 2-bit display mode and a sprite flag with the sprite's own index;
- the colour that the palette lookup already produced;
- a bypass control bit.

With bypass clear it passes the palette colour to the output. With bypass set it ignores the palette result and shows the index itself as a grey level, with the same value on red, green and blue.

In bypass, the bits that carry control meaning in the current display mode are forced to zero, and all other bits keep their positions:

- In half-bright mode the darkening flag (bit 5) is cleared.
- In the 6-plane hold-modify mode the two control planes (bits 5:4) are cleared.
- In the 8-plane hold-modify mode the two control planes (bits 1:0) are cleared.

When a sprite owns the pixel, its index is shown unchanged, whatever the display mode.

Both paths pass through exactly one register, so changing the bypass bit from one pixel to the next never moves pixels on screen.

Top module: `gray_bypass_fmt`

## Requirements
- R1: A rising clock edge with `rst_n` low sets all three output components to zero.
- R2: With `bypass_en` low, one cycle later `out_r`, `out_g` and `out_b` equal `pal_rgb[23:16]`, `pal_rgb[15:8]` and `pal_rgb[7:0]` of the sampled input.
- R3: With `bypass_en` high, one cycle later the three output components are equal (grayscale).
- R4: With bypass, no sprite and `pix_mode` = 0 (direct), the output equals `pix_idx` unchanged.
- R5: With bypass, no sprite and `pix_mode` = 1 (half-bright), the output is `pix_idx` with bit 5 forced to 0. All other bits keep their positions.
- R6: With bypass, no sprite and `pix_mode` = 2 (6-plane hold-modify), the output is `pix_idx` with bits 5 and 4 forced to 0.
- R7: With bypass, no sprite and `pix_mode` = 3 (8-plane hold-modify), the output is `pix_idx` with bits 1 and 0 forced to 0.
- R8: With bypass and `spr_hit` high, the output equals `spr_idx` unchanged in every mode. `pix_idx` has no effect.
- R9: Both paths have a latency of exactly one clock. Toggling `bypass_en` on consecutive pixels gives each pixel's own result on the next cycle.
- R10: With bypass set, `pal_rgb` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_idx | input | 8 | Playfield pixel index |
| pix_mode | input | 2 | 0 direct, 1 half-bright, 2 hold-modify 6-plane, 3 hold-modify 8-plane |
| spr_hit | input | 1 | A sprite owns this pixel |
| spr_idx | input | 8 | Sprite palette index |
| pal_rgb | input | 24 | Palette colour, red in bits 23:16, blue in bits 7:0 |
| bypass_en | input | 1 | Skip the palette and output the index as grey |
| out_r | output | 8 | Red component, registered |
| out_g | output | 8 | Green component, registered |
| out_b | output | 8 | Blue component, registered |

## Verification
The only state in this block is the output register, so any fault appears at the ports on the cycle after the pixel that caused it:

- a wrong mask shows up as a set control bit in that pixel's grey value;
- a wrong source selection shows up as the pixel index where the sprite index belongs, or the reverse;
- a broken replication shows up as unequal components.

A missing or extra pipeline stage appears as a one-pixel shift whenever the bypass bit changes between neighbouring pixels. The bench changes the bypass bit on every pixel of a sequence to expose it.

// File: rtl/gbf_pkg.sv
// Package: shared types for the palette bypass output formatter.
// Assumes a 2-bit display mode encoding fixed by the pixel decoder upstream.
package gbf_pkg;
    typedef enum logic [1:0] {
        MODE_DIRECT     = 2'd0,
        MODE_HALFBRIGHT = 2'd1,
        MODE_HOLD6      = 2'd2,
        MODE_HOLD8      = 2'd3
    } pix_mode_e;
endpackage

// File: rtl/gbf_ctrl_mask.sv
// Module: gbf_ctrl_mask
// Clears the index bits that carry control meaning in the current display
// mode. Every other bit keeps its position. Purely combinational.
// Assumes the control field positions given by the parameters lie inside IDX_W.
module gbf_ctrl_mask
    import gbf_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int HALF_BIT = 5,
    parameter int HOLD6_LO = 4,
    parameter int HOLD8_LO = 0
) (
    input  pix_mode_e          mode,
    input  logic [IDX_W-1:0]   idx,
    output logic [IDX_W-1:0]   idx_clean
);
    logic [IDX_W-1:0] keep;

    // Per bit: decide whether the current mode reserves this bit position.
    for (genvar i = 0; i < IDX_W; i++) begin : g_bit
        localparam bit IN_HALF  = (i == HALF_BIT);
        localparam bit IN_HOLD6 = (i == HOLD6_LO) || (i == HOLD6_LO + 1);
        localparam bit IN_HOLD8 = (i == HOLD8_LO) || (i == HOLD8_LO + 1);
        always_comb begin
            unique case (mode)
                MODE_HALFBRIGHT: keep[i] = !IN_HALF;
                MODE_HOLD6:      keep[i] = !IN_HOLD6;
                MODE_HOLD8:      keep[i] = !IN_HOLD8;
                default:         keep[i] = 1'b1;
            endcase
        end
    end

    // Apply the keep mask to the incoming index.
    assign idx_clean = idx & keep;
endmodule

// File: rtl/gbf_src_sel.sv
// Module: gbf_src_sel
// Picks the grey source: the sprite index when a sprite owns the pixel,
// otherwise the playfield index with its control bits masked. The chosen
// index is then widened or narrowed to one colour component.
// Assumes the sprite index is already free of control bits.
module gbf_src_sel
    import gbf_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  pix_mode_e          mode,
    input  logic [IDX_W-1:0]   pix_idx,
    input  logic               spr_hit,
    input  logic [IDX_W-1:0]   spr_idx,
    output logic [COMP_W-1:0]  gray
);
    logic [IDX_W-1:0] pix_clean;
    logic [IDX_W-1:0] chosen;

    gbf_ctrl_mask #(.IDX_W(IDX_W)) u_mask (
        .mode      (mode),
        .idx       (pix_idx),
        .idx_clean (pix_clean)
    );

    // Sprite pixels bypass the mode masking entirely.
    always_comb chosen = spr_hit ? spr_idx : pix_clean;

    // Fit the index into one component: zero-extend above it or keep its low bits.
    if (COMP_W >= IDX_W) begin : g_widen
        assign gray = {{(COMP_W-IDX_W){1'b0}}, chosen};
    end else begin : g_narrow
        assign gray = chosen[COMP_W-1:0];
    end
endmodule

// File: rtl/gbf_out_stage.sv
// Module: gbf_out_stage
// The single output register. It loads either the palette colour or the
// grey value copied to all three components.
// Assumes a synchronous active-low reset.
module gbf_out_stage #(
    parameter int COMP_W = 8,
    localparam int RGB_W = 3 * COMP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bypass,
    input  logic [RGB_W-1:0]   pal_rgb,
    input  logic [COMP_W-1:0]  gray,
    output logic [RGB_W-1:0]   rgb_q
);
    logic [RGB_W-1:0] rgb_d;

    // Choose the next colour: palette result or replicated grey.
    always_comb rgb_d = bypass ? {3{gray}} : pal_rgb;

    // Register the colour once for both paths.
    always_ff @(posedge clk) begin
        if (!rst_n) rgb_q <= '0;
        else        rgb_q <= rgb_d;
    end
endmodule

// File: rtl/gray_bypass_fmt.sv
// Module: gray_bypass_fmt (top)
// Palette bypass output formatter. Forwards the palette colour, or shows the
// mode-masked pixel index (or the sprite index) as grey, after one register.
// Assumes the palette colour belongs to the same pixel as the index.
module gray_bypass_fmt
    import gbf_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    localparam int RGB_W = 3 * COMP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   pix_idx,
    input  logic [1:0]         pix_mode,
    input  logic               spr_hit,
    input  logic [IDX_W-1:0]   spr_idx,
    input  logic [RGB_W-1:0]   pal_rgb,
    input  logic               bypass_en,
    output logic [COMP_W-1:0]  out_r,
    output logic [COMP_W-1:0]  out_g,
    output logic [COMP_W-1:0]  out_b
);
    logic [COMP_W-1:0] gray;
    logic [RGB_W-1:0]  rgb_q;

    gbf_src_sel #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_sel (
        .mode    (pix_mode_e'(pix_mode)),
        .pix_idx (pix_idx),
        .spr_hit (spr_hit),
        .spr_idx (spr_idx),
        .gray    (gray)
    );

    gbf_out_stage #(.COMP_W(COMP_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .bypass  (bypass_en),
        .pal_rgb (pal_rgb),
        .gray    (gray),
        .rgb_q   (rgb_q)
    );

    // Split the registered colour into its three components.
    assign out_r = rgb_q[3*COMP_W-1:2*COMP_W];
    assign out_g = rgb_q[2*COMP_W-1:COMP_W];
    assign out_b = rgb_q[COMP_W-1:0];

    // R2: palette colour appears one cycle later when bypass was clear.
    p_pal_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bypass_en)) |-> ({out_r, out_g, out_b} == $past(pal_rgb)));

    // R3: bypass output is grey.
    p_gray_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bypass_en)) |-> (out_r == out_g && out_g == out_b));

    // R5: the half-bright flag never reaches the output.
    p_half_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bypass_en) && !$past(spr_hit) && $past(pix_mode) == 2'd1)
        |-> (out_r[5] == 1'b0));

    // R6: the 6-plane control bits never reach the output.
    p_hold6_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bypass_en) && !$past(spr_hit) && $past(pix_mode) == 2'd2)
        |-> (out_r[5:4] == 2'b00));

    // R7: the 8-plane control bits never reach the output.
    p_hold8_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bypass_en) && !$past(spr_hit) && $past(pix_mode) == 2'd3)
        |-> (out_r[1:0] == 2'b00));

    // R8: a sprite index is shown unchanged.
    p_sprite_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bypass_en) && $past(spr_hit))
        |-> (out_r == COMP_W'($past(spr_idx))));
endmodule

// File: tb/gray_bypass_fmt_bench.sv
`timescale 1ns/1ps
module gray_bypass_fmt_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pix_idx = '0;
    logic [1:0]  pix_mode = '0;
    logic        spr_hit = 1'b0;
    logic [7:0]  spr_idx = '0;
    logic [23:0] pal_rgb = '0;
    logic        bypass_en = 1'b0;
    logic [7:0]  out_r, out_g, out_b;
    int          n_run = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    gray_bypass_fmt u_gray_bypass_fmt (
        .clk(clk), .rst_n(rst_n), .pix_idx(pix_idx), .pix_mode(pix_mode),
        .spr_hit(spr_hit), .spr_idx(spr_idx), .pal_rgb(pal_rgb),
        .bypass_en(bypass_en), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    // Expected grey value, derived from the requirements.
    function automatic logic [7:0] exp_gray(logic [1:0] m, logic [7:0] idx);
        case (m)
            2'd1:    return idx & 8'hDF;
            2'd2:    return idx & 8'hCF;
            2'd3:    return idx & 8'hFC;
            default: return idx;
        endcase
    endfunction

    task automatic check(string req, logic [23:0] act, logic [23:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive one pixel at the falling edge. It is captured at the next rising edge.
    task automatic drive(logic byp, logic [1:0] m, logic [7:0] idx, logic sh,
                         logic [7:0] si, logic [23:0] pal);
        @(negedge clk);
        bypass_en = byp; pix_mode = m; pix_idx = idx;
        spr_hit = sh; spr_idx = si; pal_rgb = pal;
    endtask

    task automatic settle();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        drive(1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 24'hABCDEF);
        settle();
        check("R1", {out_r, out_g, out_b}, 24'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_palette();
        drive(1'b0, 2'd2, 8'h3F, 1'b0, 8'h00, 24'h123456); settle();
        check("R2", {out_r, out_g, out_b}, 24'h123456);
        drive(1'b0, 2'd3, 8'hFF, 1'b1, 8'h77, 24'hFEDCBA); settle();
        check("R2", {out_r, out_g, out_b}, 24'hFEDCBA);
    endtask

    task automatic t_modes();
        for (int m = 0; m < 4; m++) begin
            logic [7:0] e;
            string      rq;
            rq = (m == 0) ? "R4" : (m == 1) ? "R5" : (m == 2) ? "R6" : "R7";
            drive(1'b1, 2'(m), 8'hFF, 1'b0, 8'h00, 24'h000000); settle();
            e = exp_gray(2'(m), 8'hFF);
            check(rq, {out_r, out_g, out_b}, {3{e}});
            drive(1'b1, 2'(m), 8'hA7, 1'b0, 8'h00, 24'h111111); settle();
            e = exp_gray(2'(m), 8'hA7);
            check(rq, {out_r, out_g, out_b}, {3{e}});
        end
        // R3: grey on all components for a sparse index.
        drive(1'b1, 2'd0, 8'h5A, 1'b0, 8'h00, 24'h000000); settle();
        check("R3", {out_g, out_b, out_r}, {3{8'h5A}});
    endtask

    task automatic t_sprite();
        for (int m = 0; m < 4; m++) begin
            drive(1'b1, 2'(m), 8'h11, 1'b1, 8'hF3, 24'h999999); settle();
            check("R8", {out_r, out_g, out_b}, {3{8'hF3}});
        end
    endtask

    task automatic t_pal_ignored();
        drive(1'b1, 2'd0, 8'h42, 1'b0, 8'h00, 24'hFFFFFF); settle();
        check("R10", {out_r, out_g, out_b}, {3{8'h42}});
        drive(1'b1, 2'd0, 8'h42, 1'b0, 8'h00, 24'h0F0F0F); settle();
        check("R10", {out_r, out_g, out_b}, {3{8'h42}});
    endtask

    task automatic t_latency();
        drive(1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 24'hA1B2C3); settle();
        drive(1'b1, 2'd2, 8'hFF, 1'b0, 8'h00, 24'h000000);
        #0.5;
        check("R9", {out_r, out_g, out_b}, 24'hA1B2C3); // not yet updated
        settle();
        check("R9", {out_r, out_g, out_b}, {3{8'hCF}});
        drive(1'b0, 2'd2, 8'hFF, 1'b0, 8'h00, 24'h0D0E0F); settle();
        check("R9", {out_r, out_g, out_b}, 24'h0D0E0F);
        drive(1'b1, 2'd3, 8'h7F, 1'b0, 8'h00, 24'h0D0E0F); settle();
        check("R9", {out_r, out_g, out_b}, {3{8'h7C}});
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_palette();
                t_modes();
                t_sprite();
                t_pal_ignored();
                t_latency();
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule